// File: doc/BRIEF.md
# Page Write Buffer and Programming Sequencer

This block sits behind a serial memory interface. It gathers the data bytes of one write transaction into a 16-entry page buffer and later commits them to a 128 x 8 nonvolatile array as one self-timed programming cycle. The serial decoder in front of it gives three kinds of event. A word-address load opens a transaction and sets the page and the in-page position. A byte strobe delivers one data byte. A STOP strobe closes the transaction.

Each buffer entry carries a written flag. When STOP arrives, only flagged entries are sent to the array's write port, and unflagged bytes of the page keep their old contents. The programming time is a parameterised clock count that stands for the array's write cycle time. For the whole of that time the block reports busy and takes no new events. A write-protect input that is high at STOP makes the block drop the collected bytes without any programming.

Top module: `pgw_top`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `mem_we` are low and no buffer entry is marked written.
- R2: An address load takes bits [6:4] of `addr_in` as the page and bits [3:0] as the in-page position. Each accepted byte lands at the current position, and the position then advances by one in its four low bits only, so the page never changes within a transaction.
- R3: If more than 16 bytes arrive before STOP, the position wraps from 15 to 0 inside the same page. A later byte then replaces the earlier byte at that position, and only the last byte for each position is programmed.
- R4: `mem_we` is never asserted while bytes are being collected. The array is written only during a programming cycle.
- R5: A STOP that arrives while idle, with at least one written entry and `wp` low, raises `busy` on the following clock. `busy` then stays high for exactly `WR_CYCLES` clock cycles.
- R6: A programming cycle asserts `mem_we` exactly once for each written entry, with `mem_addr` = {page, position} and that entry's byte. No other array location is written.
- R7: A STOP after an address load with no data bytes (a dummy write) leaves `busy` low and writes nothing.
- R8: If `wp` is high when STOP arrives, nothing is programmed and `busy` stays low. The collected bytes are discarded, so a later STOP with no new bytes starts no cycle.
- R9: While `busy` is high, address loads, byte strobes and STOP strobes are ignored. They change neither the array nor the buffer seen by the next transaction.
- R10: The written flags are cleared in the same clock cycle that `busy` falls. A new address load also clears any uncommitted flags, so only bytes written after the most recent load are programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | One-cycle strobe: load page and position from `addr_in` |
| addr_in | input | 7 | Word address of the transaction |
| byte_stb | input | 1 | One-cycle strobe: a data byte is present on `byte_in` |
| byte_in | input | 8 | Data byte |
| stop_stb | input | 1 | One-cycle strobe: the transaction ended with STOP |
| wp | input | 1 | Write protect; high makes the whole array read-only |
| busy | output | 1 | High during a programming cycle |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 7 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The assertions check four things on every cycle: that a qualifying STOP raises busy and a blocked or empty one does not, that each busy period lasts exactly the configured count, that every array write stays inside the loaded page, and that no written flag survives the end of a cycle. Three behaviours can only be shown by the bench's scenarios, because they depend on the contents of a whole page: which bytes survive a wrap, that unaddressed neighbours keep their data, and that events sent during busy leave no trace in the array. The bench shows these by comparing a model of the full array after each transaction and by counting write strobes.

// File: rtl/pgw_pkg.sv
// Package: types shared by the page-write buffer and its sequencer.
// Assumes nothing beyond a standard SystemVerilog compile order (this file first).
package pgw_pkg;
    // Programming sequencer states.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_PROG = 1'b1
    } seq_state_e;
endpackage

// File: rtl/pgw_buffer.sv
// Module: pgw_buffer
// Holds one page of pending write data: a page base, an in-page position
// that wraps on its low bits, and per-entry data with a written flag.
// Assumes address load and byte strobe are never high in the same cycle;
// if they are, the load wins and the byte is dropped.
module pgw_buffer #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int OFS_W  = 4,
    localparam int PG_W    = ADDR_W - OFS_W,
    localparam int ENTRIES = 1 << OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              discard,
    input  logic              clear,
    input  logic [OFS_W-1:0]  rd_idx,
    output logic              any_valid,
    output logic [PG_W-1:0]   page,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [OFS_W-1:0]  pos_q;
    logic [PG_W-1:0]   page_q;
    logic [ENTRIES-1:0] valid_vec;
    logic [DATA_W-1:0] data_arr [ENTRIES];

    logic take_load;
    logic take_byte;
    assign take_load = accept && addr_load;
    assign take_byte = accept && byte_stb && !addr_load;

    // Page base and in-page position; position advances on its low bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            page_q <= '0;
        end else if (take_load) begin
            page_q <= addr_in[ADDR_W-1:OFS_W];
            pos_q  <= addr_in[OFS_W-1:0];
        end else if (take_byte) begin
            pos_q  <= pos_q + 1'b1;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : gen_ent
        logic              valid_r;
        logic [DATA_W-1:0] data_r;

        // Written flag: set on a byte at this position, cleared on commit end, discard or new load.
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid_r <= 1'b0;
            else if (clear || discard || take_load)
                valid_r <= 1'b0;
            else if (take_byte && pos_q == OFS_W'(g))
                valid_r <= 1'b1;
        end

        // Entry data: the latest byte for this position replaces the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_r <= '0;
            else if (take_byte && pos_q == OFS_W'(g))
                data_r <= byte_in;
        end

        assign valid_vec[g] = valid_r;
        assign data_arr[g]  = data_r;
    end

    assign any_valid = |valid_vec;
    assign page      = page_q;
    assign rd_valid  = valid_vec[rd_idx];
    assign rd_data   = data_arr[rd_idx];

    // A byte accepted at position p moves the position to p+1 modulo the page size.
    p_pos_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_byte |=> pos_q == $past(pos_q) + 1'b1);

    // A page stays fixed unless a new address load is accepted.
    p_page_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !take_load |=> $stable(page_q));
endmodule

// File: rtl/pgw_sequencer.sv
// Module: pgw_sequencer
// Starts a self-timed programming cycle on a qualifying STOP, scans the
// buffer entries during the first ENTRIES cycles of the cycle, and issues one
// array write for each written entry. It ends the cycle after WR_CYCLES clocks.
// Assumes WR_CYCLES > ENTRIES so that the scan fits inside the cycle.
module pgw_sequencer
    import pgw_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int OFS_W     = 4,
    parameter int WR_CYCLES = 40,
    localparam int PG_W    = ADDR_W - OFS_W,
    localparam int ENTRIES = 1 << OFS_W,
    localparam int CNT_W   = $clog2(WR_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_stb,
    input  logic              wp,
    input  logic              any_valid,
    input  logic [PG_W-1:0]   page,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic [OFS_W-1:0]  rd_idx,
    output logic              busy,
    output logic              discard,
    output logic              done,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start;

    assign busy    = (state_q == SEQ_PROG);
    assign start   = stop_stb && !busy && any_valid && !wp;
    assign discard = stop_stb && !busy && wp;
    assign done    = busy && (cnt_q == CNT_W'(WR_CYCLES - 1));

    // Cycle state and its clock counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else if (start) begin
            state_q <= SEQ_PROG;
            cnt_q   <= '0;
        end else if (done) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else if (busy) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Write port: entry index follows the counter during the scan window.
    assign rd_idx    = cnt_q[OFS_W-1:0];
    assign mem_we    = busy && (cnt_q < CNT_W'(ENTRIES)) && rd_valid;
    assign mem_addr  = {page, rd_idx};
    assign mem_wdata = rd_data;

    // An array write only happens inside a programming cycle.
    p_we_in_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // A STOP seen during a cycle neither restarts nor extends it.
    p_stop_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy && cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/pgw_top.sv
// Module: pgw_top
// Page write buffer plus programming sequencer. Bytes of a write transaction
// are collected into a one-page buffer and committed to the external array
// through the mem_* port after STOP, as one timed cycle reported by busy.
// Assumes the serial decoder supplies single-cycle strobes that are already
// synchronised to clk.
module pgw_top #(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int OFS_W     = 4,
    parameter int WR_CYCLES = 40,
    localparam int PG_W  = ADDR_W - OFS_W,
    localparam int CNT_W = $clog2(WR_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              stop_stb,
    input  logic              wp,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    logic              any_valid;
    logic [PG_W-1:0]   page;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [OFS_W-1:0]  rd_idx;
    logic              discard;
    logic              done;

    pgw_buffer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (!busy),
        .addr_load (addr_load),
        .addr_in   (addr_in),
        .byte_stb  (byte_stb),
        .byte_in   (byte_in),
        .discard   (discard),
        .clear     (done),
        .rd_idx    (rd_idx),
        .any_valid (any_valid),
        .page      (page),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    pgw_sequencer #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .OFS_W     (OFS_W),
        .WR_CYCLES (WR_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_stb  (stop_stb),
        .wp        (wp),
        .any_valid (any_valid),
        .page      (page),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .busy      (busy),
        .discard   (discard),
        .done      (done),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // Length of the current busy run, kept only for the duration check.
    logic [CNT_W-1:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)
            run_q <= '0;
        else
            run_q <= run_q + 1'b1;
    end

    p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_stb && !busy && any_valid && !wp) |=> busy);

    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == CNT_W'(WR_CYCLES));

    // Empty (dummy) or protected STOP starts nothing (R7, R8).
    p_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_stb && !busy && (!any_valid || wp)) |=> !busy);

    p_write_in_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[ADDR_W-1:OFS_W] == page);

    p_flags_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !any_valid);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> !busy && !mem_we);
endmodule

// File: tb/pgw_top_tb.sv
// Directed bench for pgw_top: one task per scenario, each checking against
// a bench-side model of the array and of the pending page.
module pgw_top_tb;
    localparam int WR = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_load = 1'b0;
    logic [6:0] addr_in = '0;
    logic       byte_stb = 1'b0;
    logic [7:0] byte_in = '0;
    logic       stop_stb = 1'b0;
    logic       wp = 1'b0;
    logic       busy;
    logic       mem_we;
    logic [6:0] mem_addr;
    logic [7:0] mem_wdata;

    pgw_top #(.WR_CYCLES(WR)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_in(byte_in), .stop_stb(stop_stb), .wp(wp),
        .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always #4 clk = ~clk;

    // Array model driven by the write port, and a strobe counter.
    logic [7:0] mem [128];
    int we_cnt = 0;
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    // Expected state, computed from the requirements.
    logic [7:0] exp_mem [128];
    logic [7:0] p_data [16];
    bit         p_val [16];
    logic [2:0] m_page;
    logic [3:0] m_pos;
    bit         m_busy = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic load(input logic [6:0] a);
        addr_load = 1'b1; addr_in = a;
        if (!m_busy) begin
            m_page = a[6:4]; m_pos = a[3:0];
            for (int i = 0; i < 16; i++) p_val[i] = 0;
        end
        @(negedge clk);
        addr_load = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        byte_stb = 1'b1; byte_in = b;
        if (!m_busy) begin
            p_data[m_pos] = b; p_val[m_pos] = 1; m_pos = m_pos + 4'd1;
        end
        @(negedge clk);
        byte_stb = 1'b0;
    endtask

    task automatic stop();
        bit any = 0;
        stop_stb = 1'b1;
        if (!m_busy) begin
            for (int i = 0; i < 16; i++) any |= p_val[i];
            if (any && !wp) begin
                for (int i = 0; i < 16; i++)
                    if (p_val[i]) exp_mem[{m_page, 4'(i)}] = p_data[i];
                m_busy = 1;
            end
            if (any && !wp || wp)
                for (int i = 0; i < 16; i++) p_val[i] = 0;
        end
        @(negedge clk);
        stop_stb = 1'b0;
    endtask

    // Count remaining busy cycles and compare with the expected count.
    task automatic wait_idle(input int expn, input string req);
        int n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        m_busy = 0;
        chk(n == expn, req, "busy cycles", n, expn);
    endtask

    task automatic check_mem(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 128; i++)
            if (mem[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first < 0) chk(1, req, "array", 0, 0);
        else chk(0, req, $sformatf("array[%0h]", first), mem[first], exp_mem[first]);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(mem_we == 1'b0, "R1", "mem_we after reset", mem_we, 0);
        stop();  // no written entry may exist after reset
        chk(busy == 1'b0, "R1", "busy after empty STOP", busy, 0);
    endtask

    task automatic t_byte();
        int w0 = we_cnt;
        load(7'h25); send(8'h5C); stop();
        wait_idle(WR, "R5");
        chk(we_cnt - w0 == 1, "R6", "single byte writes", we_cnt - w0, 1);
        check_mem("R6");
    endtask

    task automatic t_full_page();
        int w0 = we_cnt;
        load(7'h30);
        for (int i = 0; i < 16; i++) send(8'(8'h80 + i));
        chk(we_cnt == w0, "R4", "writes before STOP", we_cnt - w0, 0);
        check_mem("R4");
        stop();
        wait_idle(WR, "R5");
        chk(we_cnt - w0 == 16, "R6", "full page writes", we_cnt - w0, 16);
        check_mem("R2");
    endtask

    task automatic t_wrap();
        int w0 = we_cnt;
        load(7'h4E);
        for (int i = 0; i < 20; i++) send(8'(8'h10 + 3 * i));
        stop();
        wait_idle(WR, "R3");
        chk(we_cnt - w0 == 16, "R3", "wrap writes", we_cnt - w0, 16);
        check_mem("R3");
    endtask

    task automatic t_partial();
        int w0 = we_cnt;
        load(7'h63); send(8'hD1); send(8'hD2); send(8'hD3); stop();
        wait_idle(WR, "R6");
        chk(we_cnt - w0 == 3, "R6", "partial writes", we_cnt - w0, 3);
        check_mem("R6");
    endtask

    task automatic t_dummy();
        int w0 = we_cnt;
        load(7'h10); stop();
        chk(busy == 1'b0, "R7", "busy after dummy write", busy, 0);
        wait_idle(0, "R7");
        chk(we_cnt == w0, "R7", "dummy writes", we_cnt - w0, 0);
    endtask

    task automatic t_protect();
        int w0 = we_cnt;
        wp = 1'b1;
        load(7'h52);
        for (int i = 0; i < 4; i++) send(8'(8'hE0 + i));
        stop();
        chk(busy == 1'b0, "R8", "busy under protect", busy, 0);
        wp = 1'b0;
        stop();
        chk(busy == 1'b0, "R8", "busy after discard", busy, 0);
        chk(we_cnt == w0, "R8", "protected writes", we_cnt - w0, 0);
        check_mem("R8");
    endtask

    task automatic t_busy_ignore();
        int w0 = we_cnt;
        load(7'h70); send(8'hA1); send(8'hA2); stop();
        load(7'h00); send(8'hFF); stop();
        wait_idle(WR - 3, "R9");
        chk(we_cnt - w0 == 2, "R9", "writes with events in busy", we_cnt - w0, 2);
        check_mem("R9");
        stop();
        chk(busy == 1'b0, "R9", "STOP after cycle, nothing pending", busy, 0);
    endtask

    task automatic t_reload();
        int w0 = we_cnt;
        load(7'h08); send(8'h11); send(8'h22);
        load(7'h18); send(8'h33); stop();
        wait_idle(WR, "R10");
        chk(we_cnt - w0 == 1, "R10", "writes after reload", we_cnt - w0, 1);
        check_mem("R10");
        w0 = we_cnt;
        load(7'h5A); send(8'h44); stop();
        wait_idle(WR, "R10");
        chk(we_cnt - w0 == 1, "R10", "no leftover flags", we_cnt - w0, 1);
        check_mem("R10");
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem[i] = 8'(8'hC3 ^ i);
            exp_mem[i] = 8'(8'hC3 ^ i);
        end
        for (int i = 0; i < 16; i++) p_val[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_byte();
        t_full_page();
        t_wrap();
        t_partial();
        t_dummy();
        t_protect();
        t_busy_ignore();
        t_reload();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule